// File: doc/BRIEF.md
# JTAG Serial Port Byte Exchanger

This block is a character channel that a debug host reaches through a JTAG data-register scan. Every scan is one 72-bit frame made of a count byte and eight byte slots. In a single scan the host delivers up to eight bytes, which enter a receive FIFO that a UART-like target peripheral drains. In the same scan the host collects up to eight bytes that the peripheral queued in a transmit FIFO. The returned count byte gives the number of bytes the target is sending. It also gives the receive space the host may fill on its next scan.

The whole block runs on one clock. The scan controls (`dr_capture`, `dr_shift`, `dr_update`) are single-cycle qualifiers that are honoured only while `dr_sel` is high. At capture the block loads its count byte and the queued transmit bytes into the shift register, and it latches both counts. The FIFOs change only at update, and each is limited to the counts latched at capture. The target side pushes and pops one byte per clock.

Top module: `jsp_exchanger`

## Requirements
- R1: After reset `dr_tdo` is 0, `tx_full` is 0, `rx_empty` is 1, and both FIFOs are empty.
- R2: At capture, frame bits [7:4] hold min(transmit occupancy, 8) and frame bits [3:0] hold min(receive free space, 8).
- R3: At capture, slot k (frame bits 8k+15..8k+8, k = 0..7) holds the k-th oldest transmit byte when k is below the send count, and zero otherwise.
- R4: On each shift cycle `dr_tdo` presents frame bit 0 and the frame moves one place toward bit 0, with `dr_tdi` entering at bit 71. The count byte therefore leaves first, then slot 0, each least significant bit first.
- R5: At update, exactly the send count latched at the preceding capture is removed from the head of the transmit FIFO.
- R6: At update the host count is taken from frame bits [7:4], and a value above 8 counts as 8. The number accepted is min(host count, free count latched at capture). That many slots, slot 0 first, are appended to the receive FIFO. Later slots are ignored, and the receive FIFO never overflows.
- R7: While `dr_sel` is low, capture, shift and update have no effect on the frame, on `dr_tdo` or on either FIFO.
- R8: A `tx_push` while `tx_full` is high is ignored, and so is an `rx_pop` while `rx_empty` is high. `tx_full` is set when the transmit FIFO holds `FIFO_DEPTH` bytes.
- R9: An update with no capture since the previous update moves no bytes in either direction.
- R10: A byte pushed by the target between capture and update stays queued, and it is offered on the next scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan and system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dr_sel | input | 1 | This data register is selected |
| dr_capture | input | 1 | Capture qualifier |
| dr_shift | input | 1 | Shift qualifier |
| dr_update | input | 1 | Update qualifier |
| dr_tdi | input | 1 | Serial data from the host |
| dr_tdo | output | 1 | Serial data to the host |
| tx_push | input | 1 | Target queues a byte for the host |
| tx_byte | input | 8 | Byte to queue |
| tx_full | output | 1 | Transmit FIFO is full |
| rx_pop | input | 1 | Target takes the head receive byte |
| rx_byte | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO is empty |

## Verification
The bench builds the block with `FIFO_DEPTH` = 16, twice the per-scan slot count. This makes both clamps reachable. Eleven queued bytes drive the send count to its cap of 8, and an empty receive FIFO advertises 8 even though 16 entries are free. The receive FIFO can also be filled completely, so that 0 is advertised and 3 is advertised after three pops. The transmit FIFO can be filled to its full level so that a seventeenth push is dropped.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int SLOT_N  = 8;
  localparam int BYTE_W  = 8;
  localparam int NIB_W   = 4;
  localparam int FRAME_W = BYTE_W * (SLOT_N + 1);
  localparam int SLOT_CW = $clog2(SLOT_N + 1);

  typedef enum logic [1:0] {
    SCAN_IDLE,
    SCAN_CAPTURE,
    SCAN_SHIFT,
    SCAN_UPDATE
  } scan_op_e;
endpackage

// File: rtl/jsp_fifo.sv
module jsp_fifo #(
  parameter  int DEPTH  = 16,
  parameter  int LANES  = 8,
  parameter  int PEEK_N = 8,
  parameter  int W      = 8,
  localparam int PW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int LW     = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [W-1:0]        push_data,
  input  logic [LW-1:0]       bulk_wr_cnt,
  input  logic [LANES*W-1:0]  bulk_wr_data,
  input  logic                pop,
  input  logic [LW-1:0]       bulk_pop_cnt,
  output logic [PEEK_N*W-1:0] peek_data,
  output logic [CW-1:0]       count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] wr_n, rd_n;

  always_comb begin
    wr_n   = push ? LW'(1) : bulk_wr_cnt;
    rd_n   = pop  ? LW'(1) : bulk_pop_cnt;
    wptr_d = wptr_q + PW'(wr_n);
    rptr_d = rptr_q + PW'(rd_n);
    cnt_d  = cnt_q + CW'(wr_n) - CW'(rd_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_n != '0) wptr_q <= wptr_d;
      if (rd_n != '0) rptr_q <= rptr_d;
      if ((wr_n != '0) || (rd_n != '0)) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wptr_q] <= push_data;
    for (int k = 0; k < LANES; k++) begin
      if (!push && (LW'(k) < bulk_wr_cnt))
        mem[wptr_q + PW'(k)] <= bulk_wr_data[k*W +: W];
    end
  end

  for (genvar g = 0; g < PEEK_N; g++) begin : g_peek
    assign peek_data[g*W +: W] = mem[rptr_q + PW'(g)];
  end

  assign count = cnt_q;

  // R6 / R8: occupancy never passes the depth
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} + (CW+1)'(wr_n)) <= (CW+1)'(DEPTH));
  // R5: never removes more than is stored
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(rd_n) <= cnt_q);
  // R6: single and bulk write paths are never used together
  assert_one_write_path_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && (bulk_wr_cnt != '0)));
endmodule

// File: rtl/jsp_shifter.sv
module jsp_shifter
  import jsp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  scan_op_e              op,
  input  logic                  tdi,
  input  logic [FRAME_W-1:0]    load_vec,
  output logic                  tdo,
  output logic [NIB_W-1:0]      host_nib,
  output logic [FRAME_W-1-BYTE_W:0] host_bytes
);
  logic [FRAME_W-1:0] sr_q, sr_d;
  logic               sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    unique case (op)
      SCAN_CAPTURE: begin sr_d = load_vec;                  sr_en = 1'b1; end
      SCAN_SHIFT:   begin sr_d = {tdi, sr_q[FRAME_W-1:1]}; sr_en = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  assign tdo        = sr_q[0];
  assign host_nib   = sr_q[BYTE_W-1:BYTE_W-NIB_W];
  assign host_bytes = sr_q[FRAME_W-1:BYTE_W];

  // R2: both count nibbles loaded at capture are within one frame
  assert_header_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SCAN_CAPTURE) |=> (sr_q[7:4] <= 4'd8) && (sr_q[3:0] <= 4'd8));
  // R4: a shift moves the previous bit 1 onto the serial output
  assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == SCAN_SHIFT) |=> (tdo == $past(sr_q[1])));
endmodule

// File: rtl/jsp_exchanger.sv
module jsp_exchanger
  import jsp_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dr_sel,
  input  logic       dr_capture,
  input  logic       dr_shift,
  input  logic       dr_update,
  input  logic       dr_tdi,
  output logic       dr_tdo,
  input  logic       tx_push,
  input  logic [7:0] tx_byte,
  output logic       tx_full,
  input  logic       rx_pop,
  output logic [7:0] rx_byte,
  output logic       rx_empty
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int LW = SLOT_CW;

  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  scan_op_e op;
  always_comb begin
    op = SCAN_IDLE;
    if (dr_sel) begin
      if (dr_capture)     op = SCAN_CAPTURE;
      else if (dr_shift)  op = SCAN_SHIFT;
      else if (dr_update) op = SCAN_UPDATE;
    end
  end

  logic [CW-1:0]              tx_cnt, rx_cnt, rx_space;
  logic [SLOT_N*BYTE_W-1:0]   tx_peek;
  logic [BYTE_W-1:0]          rx_head;
  logic [LW-1:0]              send_now, free_now;
  logic [LW-1:0]              lat_send_q, lat_send_d, lat_free_q, lat_free_d;
  logic [LW-1:0]              host_cnt, accept_n, tx_drop_n;
  logic [NIB_W-1:0]           host_nib;
  logic [SLOT_N*BYTE_W-1:0]   host_bytes;
  logic [FRAME_W-1:0]         load_vec;
  logic                       tx_push_ok, rx_pop_ok, lat_en;

  assign tx_full    = (tx_cnt == CW'(FIFO_DEPTH));
  assign rx_empty   = (rx_cnt == '0);
  assign tx_push_ok = tx_push & ~tx_full;
  assign rx_pop_ok  = rx_pop & ~rx_empty;
  assign rx_byte    = rx_head;

  always_comb begin
    rx_space = CW'(FIFO_DEPTH) - rx_cnt;
    send_now = (tx_cnt   > CW'(SLOT_N)) ? LW'(SLOT_N) : LW'(tx_cnt);
    free_now = (rx_space > CW'(SLOT_N)) ? LW'(SLOT_N) : LW'(rx_space);
  end

  assign load_vec[BYTE_W-1:0] = {NIB_W'(send_now), NIB_W'(free_now)};
  for (genvar g = 0; g < SLOT_N; g++) begin : g_slot
    assign load_vec[BYTE_W*(g+1) +: BYTE_W] =
      (LW'(g) < send_now) ? tx_peek[g*BYTE_W +: BYTE_W] : '0;
  end

  always_comb begin
    lat_send_d = lat_send_q;
    lat_free_d = lat_free_q;
    lat_en     = 1'b0;
    host_cnt   = (host_nib > NIB_W'(SLOT_N)) ? LW'(SLOT_N) : LW'(host_nib);
    accept_n   = '0;
    tx_drop_n  = '0;
    if (op == SCAN_CAPTURE) begin
      lat_send_d = send_now;
      lat_free_d = free_now;
      lat_en     = 1'b1;
    end else if (op == SCAN_UPDATE) begin
      accept_n   = (host_cnt < lat_free_q) ? host_cnt : lat_free_q;
      tx_drop_n  = lat_send_q;
      lat_send_d = '0;
      lat_free_d = '0;
      lat_en     = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      lat_send_q <= '0;
      lat_free_q <= '0;
    end else if (lat_en) begin
      lat_send_q <= lat_send_d;
      lat_free_q <= lat_free_d;
    end
  end

  jsp_shifter u_shift (
    .clk        (clk),
    .rst_n      (rst_i),
    .op         (op),
    .tdi        (dr_tdi),
    .load_vec   (load_vec),
    .tdo        (dr_tdo),
    .host_nib   (host_nib),
    .host_bytes (host_bytes)
  );

  jsp_fifo #(.DEPTH(FIFO_DEPTH), .LANES(SLOT_N), .PEEK_N(SLOT_N), .W(BYTE_W)) u_txq (
    .clk          (clk),
    .rst_n        (rst_i),
    .push         (tx_push_ok),
    .push_data    (tx_byte),
    .bulk_wr_cnt  ('0),
    .bulk_wr_data ('0),
    .pop          (1'b0),
    .bulk_pop_cnt (tx_drop_n),
    .peek_data    (tx_peek),
    .count        (tx_cnt)
  );

  jsp_fifo #(.DEPTH(FIFO_DEPTH), .LANES(SLOT_N), .PEEK_N(1), .W(BYTE_W)) u_rxq (
    .clk          (clk),
    .rst_n        (rst_i),
    .push         (1'b0),
    .push_data    ('0),
    .bulk_wr_cnt  (accept_n),
    .bulk_wr_data (host_bytes),
    .pop          (rx_pop_ok),
    .bulk_pop_cnt ('0),
    .peek_data    (rx_head),
    .count        (rx_cnt)
  );

  // R7: an unselected register keeps its serial output
  assert_idle_when_unselected_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !dr_sel |=> $stable(dr_tdo));
  // R8: a push into a full queue with no update pending leaves it full
  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (tx_full && tx_push && (op != SCAN_UPDATE)) |=> tx_full);
  // R5: update removes exactly the latched send count
  assert_update_pops_latched_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (op == SCAN_UPDATE) |=>
      (tx_cnt == $past(tx_cnt) - CW'($past(lat_send_q)) + CW'($past(tx_push_ok))));
  // R6: accepted bytes always fit the receive queue
  assert_rx_room_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (op == SCAN_UPDATE) |-> (({1'b0, rx_cnt} + (CW+1)'(accept_n)) <= (CW+1)'(FIFO_DEPTH)));
endmodule

// File: tb/sim_jsp_exchanger.sv
`timescale 1ns/1ps
module sim_jsp_exchanger;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, dr_sel, dr_capture, dr_shift, dr_update, dr_tdi;
  logic       dr_tdo, tx_push, tx_full, rx_pop, rx_empty;
  logic [7:0] tx_byte, rx_byte;

  jsp_exchanger #(.FIFO_DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .dr_sel(dr_sel), .dr_capture(dr_capture),
    .dr_shift(dr_shift), .dr_update(dr_update), .dr_tdi(dr_tdi), .dr_tdo(dr_tdo),
    .tx_push(tx_push), .tx_byte(tx_byte), .tx_full(tx_full),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .rx_empty(rx_empty)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       mq[$];
  bit [7:0] txq[$];
  bit [7:0] rxq[$];
  int       lat_send = 0;
  int       lat_free = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit txf, rxe;
    bit [7:0] b, hdr;
    bit [7:0] fresh[$];
    int send, fr, hn, acc;
    txf = (txq.size() == DEPTH);
    rxe = (rxq.size() == 0);
    if (dr_sel && dr_capture) begin
      send = (txq.size() > 8) ? 8 : txq.size();
      fr   = DEPTH - rxq.size();
      if (fr > 8) fr = 8;
      hdr = 8'(send * 16 + fr);
      mq = {};
      for (int i = 0; i < 8; i++) mq.push_back(hdr[i]);
      for (int k = 0; k < 8; k++) begin
        b = (k < send) ? txq[k] : 8'h00;
        for (int i = 0; i < 8; i++) mq.push_back(b[i]);
      end
      lat_send = send;
      lat_free = fr;
    end else if (dr_sel && dr_shift) begin
      void'(mq.pop_front());
      mq.push_back(dr_tdi);
    end else if (dr_sel && dr_update) begin
      hn  = mq[4] + 2 * mq[5] + 4 * mq[6] + 8 * mq[7];
      if (hn > 8) hn = 8;
      acc = (hn < lat_free) ? hn : lat_free;
      for (int k = 0; k < lat_send; k++) void'(txq.pop_front());
      for (int k = 0; k < acc; k++) begin
        for (int i = 0; i < 8; i++) b[i] = mq[8 + 8 * k + i];
        fresh.push_back(b);
      end
      lat_send = 0;
      lat_free = 0;
    end
    if (tx_push && !txf) txq.push_back(tx_byte);
    if (rx_pop && !rxe) void'(rxq.pop_front());
    foreach (fresh[j]) rxq.push_back(fresh[j]);
  endtask

  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check("R4 tdo", {63'd0, dr_tdo}, {63'd0, mq[0]});
    check("R8 tx_full", {63'd0, tx_full}, {63'd0, txq.size() == DEPTH});
    check("R8 rx_empty", {63'd0, rx_empty}, {63'd0, rxq.size() == 0});
    if (rxq.size() != 0) check("R6 rx_byte", {56'd0, rx_byte}, {56'd0, rxq[0]});
  endtask

  function automatic logic [63:0] mk(logic [7:0] base);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[8*k +: 8] = base + 8'(k);
    return v;
  endfunction

  task automatic push_tx(logic [7:0] b);
    tx_push = 1'b1; tx_byte = b; step(); tx_push = 1'b0;
  endtask

  task automatic pop_rx(logic [7:0] exp, string tag);
    check(tag, {56'd0, rx_byte}, {56'd0, exp});
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
  endtask

  task automatic scan(input logic s, input logic [7:0] hdr, input logic [63:0] pay,
                      input int push_at, input logic [7:0] push_b,
                      output logic [71:0] got);
    logic [71:0] v;
    v = {pay, hdr};
    dr_sel = s; dr_capture = 1'b1; step(); dr_capture = 1'b0; dr_shift = 1'b1;
    for (int i = 0; i < 72; i++) begin
      dr_tdi = v[i];
      got[i] = dr_tdo;
      if (i == push_at) begin tx_push = 1'b1; tx_byte = push_b; end
      step();
      tx_push = 1'b0;
    end
    dr_shift = 1'b0; dr_update = 1'b1; step();
    dr_update = 1'b0; dr_sel = 1'b0; dr_tdi = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [71:0] g;
    rst_n = 1'b0; dr_sel = 0; dr_capture = 0; dr_shift = 0; dr_update = 0;
    dr_tdi = 0; tx_push = 0; tx_byte = 0; rx_pop = 0;
    for (int i = 0; i < 72; i++) mq.push_back(1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 tdo", {63'd0, dr_tdo}, 64'd0);
    check("R1 tx_full", {63'd0, tx_full}, 64'd0);
    check("R1 rx_empty", {63'd0, rx_empty}, 64'd1);

    // Three queued bytes, host sends two
    push_tx(8'hA0); push_tx(8'hA1); push_tx(8'hA2);
    scan(1'b1, 8'h20, mk(8'h10), -1, 8'h00, g);
    check("R2 header", {56'd0, g[7:0]}, 64'h38);
    check("R4 first slot", {56'd0, g[15:8]}, 64'hA0);
    check("R3 slots", g[71:8], {40'd0, 8'hA2, 8'hA1, 8'hA0});
    pop_rx(8'h10, "R6 rx0");
    pop_rx(8'h11, "R6 rx1");
    check("R6 only two accepted", {63'd0, rx_empty}, 64'd1);
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R5 sent bytes popped", {56'd0, g[7:0]}, 64'h08);
    check("R3 empty slots zero", g[71:8], 64'd0);

    // Send count capped at eight
    for (int k = 0; k < 11; k++) push_tx(8'hB0 + 8'(k));
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R2 send capped", {56'd0, g[7:0]}, 64'h88);
    check("R3 eight slots", g[71:8], mk(8'hB0));
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R5 remainder", {56'd0, g[7:0]}, 64'h38);
    check("R5 remainder slots", g[71:8], {40'd0, 8'hBA, 8'hB9, 8'hB8});

    // Receive side: clamp, full, partial acceptance
    scan(1'b1, 8'hF0, mk(8'h20), -1, 8'h00, g);
    check("R2 free capped", {56'd0, g[7:0]}, 64'h08);
    scan(1'b1, 8'h80, mk(8'h30), -1, 8'h00, g);
    check("R6 free before fill", {56'd0, g[7:0]}, 64'h08);
    scan(1'b1, 8'h50, mk(8'h40), -1, 8'h00, g);
    check("R6 no room", {56'd0, g[7:0]}, 64'h00);
    pop_rx(8'h20, "R6 drain"); pop_rx(8'h21, "R6 drain"); pop_rx(8'h22, "R6 drain");
    scan(1'b1, 8'h60, mk(8'h50), -1, 8'h00, g);
    check("R6 partial room", {56'd0, g[7:0]}, 64'h03);
    for (int k = 0; k < 5; k++) pop_rx(8'h23 + 8'(k), "R6 order");
    for (int k = 0; k < 8; k++) pop_rx(8'h30 + 8'(k), "R6 order");
    for (int k = 0; k < 3; k++) pop_rx(8'h50 + 8'(k), "R6 accepted subset");
    check("R6 no extra bytes", {63'd0, rx_empty}, 64'd1);

    // Unselected scan has no effect
    push_tx(8'hC0);
    scan(1'b0, 8'h40, mk(8'h60), -1, 8'h00, g);
    check("R7 rx untouched", {63'd0, rx_empty}, 64'd1);
    scan(1'b1, 8'h40, mk(8'h60), -1, 8'h00, g);
    check("R7 tx untouched header", {56'd0, g[7:0]}, 64'h18);
    check("R7 tx untouched slot", {56'd0, g[15:8]}, 64'hC0);
    for (int k = 0; k < 4; k++) pop_rx(8'h60 + 8'(k), "R7 later scan");

    // Stray update without capture
    push_tx(8'hD0);
    dr_sel = 1'b1; dr_update = 1'b1; step(); dr_update = 1'b0; dr_sel = 1'b0;
    check("R9 no rx write", {63'd0, rx_empty}, 64'd1);
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R9 tx kept header", {56'd0, g[7:0]}, 64'h18);
    check("R9 tx kept slot", {56'd0, g[15:8]}, 64'hD0);

    // Full transmit queue and empty receive pop
    for (int k = 0; k < 17; k++) push_tx(8'hE0 + 8'(k));
    check("R8 full flag", {63'd0, tx_full}, 64'd1);
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
    check("R8 empty pop ignored", {63'd0, rx_empty}, 64'd1);
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R8 first eight", g[71:0], {mk(8'hE0), 8'h88});
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R8 second eight", g[71:0], {mk(8'hE8), 8'h88});
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R8 overflow byte dropped", g[71:0], {64'd0, 8'h08});

    // Push during a scan
    push_tx(8'h70);
    scan(1'b1, 8'h00, 64'd0, 10, 8'h71, g);
    check("R10 header", {56'd0, g[7:0]}, 64'h18);
    check("R10 captured slot", {56'd0, g[15:8]}, 64'h70);
    scan(1'b1, 8'h00, 64'd0, -1, 8'h00, g);
    check("R10 late byte kept", g[71:0], {56'd0, 8'h71, 8'h18});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule